// File: doc/BRIEF.md
# Parity-Prefiltered Content-Addressable Memory

This block is a binary content-addressable memory: software-visible storage is written by address, and lookups are made by content. The default array holds 128 entries of 32 bits. A lookup presents a key and a strobe. The block answers with a hit flag and the binary index of the matching entry.

Every entry carries one extra bit beside its data: the parity of the stored word, computed inside the block when the entry is written. A lookup first computes the parity of the key once and compares it with all stored parity bits. Only the entries whose parity agrees, and which hold valid data, have their full-width comparator enabled. The number of entries that pass this prefilter on a lookup is brought out as a debug count, so the gating can be observed from outside.

No preparation step is needed between operations. A write can be followed at once by a lookup. A lookup takes one clock edge, and its result is held until the next lookup.

Top module: `parity_cam`

## Requirements
- R1: The stored parity bit of an entry is the XOR of all bits of the written data: it is 1 for an odd number of ones and 0 for an even number. It is computed from the write data in the cycle of the write and is never supplied from outside.
- R2: On a lookup, `pass_cnt_o` gives the number of valid entries whose stored parity equals the parity of the key.
- R3: An entry matches only when it is valid, its parity agrees with the key parity, and its full data equals the key. Any match sets `hit_o` to 1.
- R4: When several entries match, `hit_addr_o` gives the lowest matching index.
- R5: When no entry matches, `hit_o` is 0 and `hit_addr_o` is 0.
- R6: Synchronous active-high reset invalidates every entry and clears `hit_o`, `hit_addr_o` and `pass_cnt_o` to 0.
- R7: Results are registered. A lookup strobed at one rising edge shows its result after that edge. The outputs hold their values while `srch_en_i` is low.
- R8: A write and a lookup at the same edge see the contents from before the write. The written entry is valid and can be found from the next lookup onward.
- R9: A write to an entry that is already valid replaces its data, so the old value no longer matches at that index.
- R10: With default parameters the array has 128 entries of 32 bits, and `hit_addr_o` is 7 bits wide, so index 127 is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W (7) | Entry index to write |
| wr_data_i | input | WIDTH (32) | Data to store |
| srch_en_i | input | 1 | Lookup strobe |
| srch_key_i | input | WIDTH (32) | Key to look up |
| hit_o | output | 1 | At least one entry matched the last lookup |
| hit_addr_o | output | ADDR_W (7) | Lowest matching index, 0 on a miss |
| pass_cnt_o | output | CNT_W (8) | Entries that passed the parity prefilter on the last lookup |

## Verification
On every cycle the assertions check that a written entry's stored parity equals the parity of its write data, and that the entry becomes valid. They also check that a hit always comes with a non-zero prefilter count, that a miss reports index 0, that the cycle after reset reports nothing, and that the outputs stay stable between lookups. Which index wins among duplicates, the exact prefilter count, read-before-write ordering and the effect of an overwrite depend on the stored contents. Only the bench's scenarios show these. They use targeted writes and full key sweeps over a filled and a half-filled array, with the expected results worked out from a model of the contents kept in the bench.

// File: rtl/parity_cam_pkg.sv
package parity_cam_pkg;

    localparam int CAM_DEPTH_DEF = 128;
    localparam int CAM_WIDTH_DEF = 32;

    // Per-entry outcome of the two comparison stages
    typedef enum logic [1:0] {
        ENT_REJECT = 2'd0,  // invalid or parity disagrees: comparator gated off
        ENT_MISS   = 2'd1,  // parity agreed, data differs
        ENT_MATCH  = 2'd2   // parity agreed, data equal
    } ent_verdict_e;

endpackage

// File: rtl/parity_cam_store.sv
module parity_cam_store #(
    parameter int DEPTH  = 128,
    parameter int WIDTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              wr_par,
    output logic [WIDTH-1:0]  ent_data [DEPTH],
    output logic [DEPTH-1:0]  ent_par,
    output logic [DEPTH-1:0]  ent_vld
);

    logic [WIDTH-1:0] data_q [DEPTH];
    logic [DEPTH-1:0] par_q;
    logic [DEPTH-1:0] vld_q;

    // Only the valid flags need reset; data and parity are qualified by them
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_addr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_addr] <= wr_data;
            par_q[wr_addr]  <= wr_par;
        end
    end

    assign ent_data = data_q;
    assign ent_par  = par_q;
    assign ent_vld  = vld_q;

endmodule

// File: rtl/parity_cam_match.sv
module parity_cam_match
    import parity_cam_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] key,
    input  logic             key_par,
    input  logic [WIDTH-1:0] ent_data [DEPTH],
    input  logic [DEPTH-1:0] ent_par,
    input  logic [DEPTH-1:0] ent_vld,
    output logic [DEPTH-1:0] pass_vec,
    output logic [DEPTH-1:0] match_vec
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ent_verdict_e verdict;
        logic         gate;

        // Stage 1: one-bit parity prefilter enables the wide comparator
        assign gate = ent_vld[g] && (ent_par[g] == key_par);

        // Stage 2: full-width comparison, only evaluated behind the gate
        always_comb begin
            if (!gate) begin
                verdict = ENT_REJECT;
            end else if (ent_data[g] == key) begin
                verdict = ENT_MATCH;
            end else begin
                verdict = ENT_MISS;
            end
        end

        assign pass_vec[g]  = (verdict != ENT_REJECT);
        assign match_vec[g] = (verdict == ENT_MATCH);
    end

endmodule

// File: rtl/parity_cam_encode.sv
module parity_cam_encode #(
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]  match_vec,
    input  logic [DEPTH-1:0]  pass_vec,
    output logic              any_hit,
    output logic [ADDR_W-1:0] first_idx,
    output logic [CNT_W-1:0]  pass_cnt
);

    // Scan from the top so the lowest set index is assigned last
    always_comb begin
        any_hit   = 1'b0;
        first_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit   = 1'b1;
                first_idx = ADDR_W'(i);
            end
        end
    end

    always_comb begin
        pass_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            pass_cnt = pass_cnt + CNT_W'(pass_vec[i]);
        end
    end

endmodule

// File: rtl/parity_cam.sv
module parity_cam
    import parity_cam_pkg::*;
#(
    parameter int DEPTH  = CAM_DEPTH_DEF,
    parameter int WIDTH  = CAM_WIDTH_DEF,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    input  logic              srch_en_i,
    input  logic [WIDTH-1:0]  srch_key_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] hit_addr_o,
    output logic [CNT_W-1:0]  pass_cnt_o
);

    logic             wr_par;
    logic             key_par;
    logic [WIDTH-1:0] ent_data [DEPTH];
    logic [DEPTH-1:0] ent_par;
    logic [DEPTH-1:0] ent_vld;
    logic [DEPTH-1:0] pass_vec;
    logic [DEPTH-1:0] match_vec;
    logic              any_hit;
    logic [ADDR_W-1:0] first_idx;
    logic [CNT_W-1:0]  pass_cnt;

    // Parity of the write word and of the key, each computed once
    assign wr_par  = ^wr_data_i;
    assign key_par = ^srch_key_i;

    parity_cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .wr_par   (wr_par),
        .ent_data (ent_data),
        .ent_par  (ent_par),
        .ent_vld  (ent_vld)
    );

    parity_cam_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match (
        .key       (srch_key_i),
        .key_par   (key_par),
        .ent_data  (ent_data),
        .ent_par   (ent_par),
        .ent_vld   (ent_vld),
        .pass_vec  (pass_vec),
        .match_vec (match_vec)
    );

    parity_cam_encode #(.DEPTH(DEPTH)) u_encode (
        .match_vec (match_vec),
        .pass_vec  (pass_vec),
        .any_hit   (any_hit),
        .first_idx (first_idx),
        .pass_cnt  (pass_cnt)
    );

    // Result registers: loaded on a lookup, held otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o      <= 1'b0;
            hit_addr_o <= '0;
            pass_cnt_o <= '0;
        end else if (srch_en_i) begin
            hit_o      <= any_hit;
            hit_addr_o <= first_idx;
            pass_cnt_o <= pass_cnt;
        end
    end

endmodule

// File: rtl/parity_cam_checker.sv
module parity_cam_checker #(
    parameter int DEPTH  = 128,
    parameter int WIDTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [WIDTH-1:0]  wr_data_i,
    input logic              srch_en_i,
    input logic              hit_o,
    input logic [ADDR_W-1:0] hit_addr_o,
    input logic [CNT_W-1:0]  pass_cnt_o,
    input logic [DEPTH-1:0]  par_vec,
    input logic [DEPTH-1:0]  vld_vec
);

    assert_par_stored_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en_i) && !$past(rst)) |-> (par_vec[$past(wr_addr_i)] == ^$past(wr_data_i)));

    assert_hit_has_pass_R3: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (pass_cnt_o != '0));

    assert_miss_addr_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (hit_addr_o == '0));

    assert_clear_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hit_o && (pass_cnt_o == '0)));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(srch_en_i) && !$past(rst)) |->
            ($stable(hit_o) && $stable(hit_addr_o) && $stable(pass_cnt_o)));

    assert_valid_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en_i) && !$past(rst)) |-> vld_vec[$past(wr_addr_i)]);

endmodule

bind parity_cam parity_cam_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .srch_en_i  (srch_en_i),
    .hit_o      (hit_o),
    .hit_addr_o (hit_addr_o),
    .pass_cnt_o (pass_cnt_o),
    .par_vec    (ent_par),
    .vld_vec    (ent_vld)
);

// File: tb/parity_cam_bench.sv
module parity_cam_bench;

    localparam int DEPTH = 128;
    localparam int WIDTH = 32;
    localparam int AW    = 7;
    localparam int CW    = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             srch_en = 1'b0;
    logic [WIDTH-1:0] key = '0;
    logic             hit;
    logic [AW-1:0]    haddr;
    logic [CW-1:0]    pcnt;

    int n_chk  = 0;
    int n_fail = 0;

    logic [WIDTH-1:0] m_data [DEPTH];
    logic             m_vld  [DEPTH];

    always #2 clk = ~clk;   // 4 ns period

    parity_cam u_parity_cam (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .srch_en_i  (srch_en),
        .srch_key_i (key),
        .hit_o      (hit),
        .hit_addr_o (haddr),
        .pass_cnt_o (pcnt)
    );

    // Expected {hit, addr, count} from the bench's own copy of the contents
    function automatic logic [15:0] model(input logic [WIDTH-1:0] k);
        logic          h = 1'b0;
        logic [AW-1:0] a = '0;
        logic [CW-1:0] c = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_vld[i] && ((^m_data[i]) == (^k))) begin
                c = c + 8'd1;
                if (!h && m_data[i] == k) begin
                    h = 1'b1;
                    a = AW'(i);
                end
            end
        end
        return {h, a, c};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual hit=%0d addr=%0d cnt=%0d expected hit=%0d addr=%0d cnt=%0d",
                     tag, act[15], act[14:8], act[7:0], exp[15], exp[14:8], exp[7:0]);
        end
    endtask

    task automatic finish_test;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    endtask

    task automatic write(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_data[a] = d;
        m_vld[a]  = 1'b1;
    endtask

    task automatic search(input string tag, input logic [WIDTH-1:0] k);
        @(negedge clk);
        srch_en = 1'b1; key = k;
        @(negedge clk);
        srch_en = 1'b0;
        check(tag, {hit, haddr, pcnt}, model(k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all): actual=timeout expected=completion");
        finish_test();
    end

    initial begin
        logic [15:0] held;
        do_reset();

        // R6: reset state of outputs, then nothing found, count zero
        check("R6 outputs after reset", {hit, haddr, pcnt}, 16'h0000);
        search("R6/R5 empty array, key 0", 32'h0);
        search("R6/R5 empty array, key all ones", 32'hFFFF_FFFF);

        // R1/R3: odd-parity word at entry 5
        write(5, 32'h0000_0007);
        search("R3 exact match at 5", 32'h0000_0007);
        search("R2 odd key passes filter, data differs", 32'h0000_0001);
        search("R1 even key rejected by parity", 32'h0000_0003);
        check("R1 even key count is zero", {8'h00, pcnt}, 16'h0000);

        // R4: duplicate below, lowest index wins
        write(2, 32'h0000_0007);
        search("R4 lowest of two matches", 32'h0000_0007);

        // R9: overwrite entry 2 with a different odd word
        write(2, 32'h8000_0000);
        search("R9 old data gone at 2", 32'h0000_0007);
        search("R9 new data found at 2", 32'h8000_0000);

        // R7: hold while strobe low and key changes
        search("R7 lookup before idle", 32'h0000_0007);
        held = {hit, haddr, pcnt};
        @(negedge clk);
        key = 32'h0000_0003;
        repeat (3) @(negedge clk);
        check("R7 outputs held while idle", {hit, haddr, pcnt}, held);

        // R8: write and lookup at the same edge see old contents
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd9; wr_data = 32'hABCD_0000;
        srch_en = 1'b1; key = 32'hABCD_0000;
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        check("R8 same-edge lookup sees old contents", {hit, haddr, pcnt}, model(32'hABCD_0000));
        m_data[9] = 32'hABCD_0000;
        m_vld[9]  = 1'b1;
        search("R8 written word found next lookup", 32'hABCD_0000);

        // R10: top index reachable
        write(127, 32'hFFFF_FFFE);
        search("R10 hit at index 127", 32'hFFFF_FFFE);

        // R6: reset clears contents
        do_reset();
        search("R6 contents cleared by reset", 32'hABCD_0000);

        // Sweep over a half-filled array (even entries only)
        for (int i = 0; i < DEPTH; i += 2) write(i, WIDTH'((i * 37 + 11) % 64));
        for (int k = 0; k < 256; k++) search("R2/R3/R5 sweep half-filled", WIDTH'(k));

        // Sweep over a full array; each value appears at i and i+64
        for (int i = 1; i < DEPTH; i += 2) write(i, WIDTH'((i * 37 + 11) % 64));
        for (int k = 0; k < 256; k++) search("R2/R3/R4/R5 sweep full", WIDTH'(k));

        finish_test();
    end

endmodule